// File: doc/BRIEF.md
# Scatter-Gather Audio DMA Channel

This block is one descriptor-driven DMA channel for an audio stream. Software loads the base address of a descriptor table and then writes a control byte to start the channel. The channel walks the table one 8-byte descriptor at a time. Each descriptor gives a buffer address and a word that holds a byte count and three flags. The channel reads each buffer through a simple request/acknowledge memory port, one 32-bit word per beat, and hands every word to the audio path as a one-cycle beat.

When a segment finishes, the channel records it in a position register. It can also post end-of-list or mark events in a status register, and these can drive an interrupt line. With looping enabled, the channel goes back to the start of the table each time it reaches end-of-list, which gives a continuous ring of segments. Without looping, it goes idle. Software can halt the channel at any time. The status bits are cleared by writing 1 to them.

Top module: `sgd_audio_dma`

## Requirements
- R1: A descriptor occupies 8 bytes in the table, and descriptors follow one another from the table base (written at register address 0). The word at the descriptor address is the buffer address. The word at the descriptor address + 4 holds the byte count in bits 23:0, the end-of-list flag in bit 31, the mark flag in bit 30 and the halt flag in bit 29.
- R2: A control write (register address 1) with bit 0 set and bit 1 clear starts an idle channel, and status bit 3 (active) rises. For each segment the buffer is read in 4-byte words at ascending addresses. The count drops by min(4, remaining) on each beat, so a segment delivers ceil(count/4) beats in table order.
- R3: When an end-of-list segment completes and looping is off, status bit 0 is set, status bit 3 clears and the memory request stops.
- R4: With control bit 2 (loop) set, completing an end-of-list segment sets status bit 0 and refetches from the table base, so the beat sequence repeats.
- R5: Completing a segment whose mark flag is set sets status bit 1.
- R6: A segment with the halt flag set makes the channel idle once it completes. No further descriptor is fetched, and this takes priority over looping.
- R7: A control write with bit 1 set halts the channel on the next clock edge. The active bit clears and the memory request drops.
- R8: Writing status (register address 2) with a 1 in bit 0 or bit 1 clears that bit. A 0 leaves it unchanged, and a new event in the same cycle wins over the clear.
- R9: The irq output, which is also status bit 2, equals (control bit 3 AND status bit 0) OR (control bit 4 AND status bit 1).
- R10: A segment with a count of zero completes without reading its buffer and still raises its events.
- R11: The position output holds the index of the last completed segment in bits 31:24 and the bytes left in the active segment in bits 23:0. The index reads 0xFF after reset and after a start until the first segment completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 table base, 1 control, 2 status |
| reg_wdata | input | 32 | Register write data |
| status_out | output | 8 | Bit0 end-of-list, bit1 mark, bit2 irq, bit3 active |
| pos_out | output | 32 | Last completed segment index and bytes remaining |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read acknowledge with data |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Audio data beat valid |
| out_data | output | 32 | Audio data word |

## Verification
A wrong segment index or descriptor address appears within one segment as beats drawn from the wrong buffer, or as a wrong index in the position output. A count that decrements wrongly gives one beat too many or too few per segment, and this shows up both in the beat stream and in the remaining-bytes field sampled in the middle of a segment. A wrong flag decode shows up at the end of a run: the wrong status bits are set, the irq level is wrong, or the channel is still active when it should have stopped, or idle when it should still be running.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  typedef enum logic [2:0] {S_IDLE, S_DESC_LO, S_DESC_HI, S_MOVE, S_SEG_END} seq_state_e;

  localparam logic [1:0] A_BASE = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam int C_GO = 0, C_HALT = 1, C_LOOP = 2, C_IE_END = 3, C_IE_MARK = 4;
  localparam int S_END = 0, S_MARK = 1, S_IRQ = 2, S_RUN = 3;
  // flag field taken from descriptor word bits 31:29
  localparam int F_END = 2, F_MARK = 1, F_HOLD = 0;

  function automatic logic [31:0] beat_take(input logic [31:0] rem, input logic [31:0] beat);
    return (rem < beat) ? rem : beat;
  endfunction
endpackage

// File: rtl/sgd_regs.sv
module sgd_regs
  import sgd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          set_end,
  input  logic          set_mark,
  input  logic          run,
  output logic          go,
  output logic          halt,
  output logic          loop_en,
  output logic [AW-1:0] tbl_base,
  output logic          irq,
  output logic [7:0]    status
);
  logic ie_end, ie_mark, st_end, st_mark;
  logic ctl_wr, st_wr;

  assign ctl_wr = wr_en && (wr_addr == A_CTRL);
  assign st_wr  = wr_en && (wr_addr == A_STAT);
  assign halt   = ctl_wr && wr_data[C_HALT];
  assign go     = ctl_wr && wr_data[C_GO] && !wr_data[C_HALT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_base <= '0;
      loop_en  <= 1'b0;
      ie_end   <= 1'b0;
      ie_mark  <= 1'b0;
      st_end   <= 1'b0;
      st_mark  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_BASE) tbl_base <= wr_data[AW-1:0];
      if (ctl_wr) begin
        loop_en <= wr_data[C_LOOP];
        ie_end  <= wr_data[C_IE_END];
        ie_mark <= wr_data[C_IE_MARK];
      end
      st_end  <= (st_end  && !(st_wr && wr_data[S_END]))  || set_end;
      st_mark <= (st_mark && !(st_wr && wr_data[S_MARK])) || set_mark;
    end
  end

  assign irq = (ie_end && st_end) || (ie_mark && st_mark);

  always_comb begin
    status         = '0;
    status[S_END]  = st_end;
    status[S_MARK] = st_mark;
    status[S_IRQ]  = irq;
    status[S_RUN]  = run;
  end

  // R8: write-one clears a status bit when no new event arrives
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wr_data[S_END] && !set_end) |=> !status[S_END]);
  // R5: a mark event is always recorded
  p_mark_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_mark |=> status[S_MARK]);
endmodule

// File: rtl/sgd_seq.sv
module sgd_seq
  import sgd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 24,
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic                   halt,
  input  logic                   loop_en,
  input  logic [AW-1:0]          tbl_base,
  output logic                   mem_req,
  output logic [AW-1:0]          mem_addr,
  input  logic                   mem_ack,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   out_valid,
  output logic [DW-1:0]          out_data,
  output logic                   set_end,
  output logic                   set_mark,
  output logic                   run,
  output logic [IDX_W+CNT_W-1:0] pos
);
  localparam int BEAT = DW / 8;

  seq_state_e       state;
  logic [AW-1:0]    desc_addr, buf_ptr;
  logic [CNT_W-1:0] remain;
  logic [2:0]       seg_fl;
  logic [IDX_W-1:0] seg_idx, done_idx;
  logic             move_beat, seg_done;

  assign move_beat = (state == S_MOVE) && (remain != '0);
  assign seg_done  = (state == S_SEG_END);
  assign set_end   = seg_done && seg_fl[F_END];
  assign set_mark  = seg_done && seg_fl[F_MARK];
  assign run       = (state != S_IDLE);
  assign out_valid = move_beat && mem_ack;
  assign out_data  = mem_rdata;
  assign pos       = {done_idx, remain};

  always_comb begin
    mem_req = (state == S_DESC_LO) || (state == S_DESC_HI) || move_beat;
    case (state)
      S_DESC_HI: mem_addr = desc_addr + AW'(4);
      S_MOVE:    mem_addr = buf_ptr;
      default:   mem_addr = desc_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      desc_addr <= '0;
      buf_ptr   <= '0;
      remain    <= '0;
      seg_fl    <= '0;
      seg_idx   <= '0;
      done_idx  <= '1;
    end else if (halt) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          desc_addr <= tbl_base;
          seg_idx   <= '0;
          done_idx  <= '1;
          remain    <= '0;
          state     <= S_DESC_LO;
        end
        S_DESC_LO: if (mem_ack) begin
          buf_ptr <= mem_rdata[AW-1:0];
          state   <= S_DESC_HI;
        end
        S_DESC_HI: if (mem_ack) begin
          remain <= mem_rdata[CNT_W-1:0];
          seg_fl <= mem_rdata[31:29];
          state  <= S_MOVE;
        end
        S_MOVE: begin
          if (remain == '0) state <= S_SEG_END;
          else if (mem_ack) begin
            remain  <= remain - CNT_W'(beat_take(32'(remain), 32'(BEAT)));
            buf_ptr <= buf_ptr + AW'(BEAT);
          end
        end
        S_SEG_END: begin
          done_idx <= seg_idx;
          if (seg_fl[F_HOLD]) state <= S_IDLE;
          else if (seg_fl[F_END]) begin
            if (loop_en) begin
              desc_addr <= tbl_base;
              seg_idx   <= '0;
              state     <= S_DESC_LO;
            end else state <= S_IDLE;
          end else begin
            desc_addr <= desc_addr + AW'(8);
            seg_idx   <= seg_idx + 1'b1;
            state     <= S_DESC_LO;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: an outstanding request keeps its address until acknowledged
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !halt) |=> (mem_req && $stable(mem_addr)));
  // R2: every accepted beat lowers the remaining count
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (move_beat && mem_ack && !halt) |=> (remain < $past(remain)));
  // R10: a drained or empty segment issues no buffer read
  p_zero_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MOVE && remain == '0) |-> !mem_req);
  // R7: halt takes effect at the next edge
  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!run && !mem_req));
  // R3: end of list without looping goes idle
  p_end_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_end && !loop_en && !halt) |=> !run);
  // R4: end of list with looping refetches the table base
  p_loop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_end && loop_en && !seg_fl[F_HOLD] && !halt) |=> (mem_req && mem_addr == $past(tbl_base)));
endmodule

// File: rtl/sgd_audio_dma.sv
module sgd_audio_dma
  import sgd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 24,
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr_en,
  input  logic [1:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [7:0]             status_out,
  output logic [IDX_W+CNT_W-1:0] pos_out,
  output logic                   irq,
  output logic                   mem_req,
  output logic [AW-1:0]          mem_addr,
  input  logic                   mem_ack,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   out_valid,
  output logic [DW-1:0]          out_data
);
  logic          go, halt, loop_en, set_end, set_mark, run;
  logic [AW-1:0] tbl_base;

  sgd_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .set_end(set_end), .set_mark(set_mark), .run(run), .go(go), .halt(halt),
    .loop_en(loop_en), .tbl_base(tbl_base), .irq(irq), .status(status_out)
  );

  sgd_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .halt(halt), .loop_en(loop_en), .tbl_base(tbl_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .set_end(set_end), .set_mark(set_mark),
    .run(run), .pos(pos_out)
  );
endmodule

// File: tb/sgd_audio_dma_tb.sv
module sgd_audio_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TBL = 32'h0000_1000;
  localparam logic [31:0] ZPTR = 32'h0003_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0] status_out;
  logic [31:0] pos_out, mem_addr, out_data;
  logic [31:0] mem_rdata = '0;
  logic irq, mem_req, out_valid;
  logic mem_ack = 1'b0;

  logic [31:0] dptr [16];
  logic [31:0] dflg [16];
  logic [31:0] got [512];
  logic [31:0] exp_d [512];
  int got_n = 0, exp_n = 0, exp_idx = 0, zero_hits = 0, wait_cnt = 0;
  bit exp_end, exp_mark, done = 0;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgd_audio_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status_out(status_out), .pos_out(pos_out), .irq(irq), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] off;
    off = a - TBL;
    if (a >= TBL && a < TBL + 32'd128) return off[2] ? dflg[off[6:3]] : dptr[off[6:3]];
    return a ^ 32'h5A5A_5A5A;
  endfunction

  // memory model: random latency, one-cycle acknowledge
  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_word(mem_addr);
        wait_cnt  <= int'($urandom % 3);
      end else wait_cnt <= wait_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (got_n < 512) got[got_n] = out_data;
      got_n++;
    end
    if (rst_n && mem_req && mem_addr == ZPTR) zero_hits++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // expected beats, events and last index from the descriptor list (R1, R2, R6)
  task automatic build_expect();
    exp_n = 0; exp_end = 0; exp_mark = 0; exp_idx = 0;
    for (int i = 0; i < 16; i++) begin
      int cnt, nb;
      cnt = int'(dflg[i][23:0]);
      nb = (cnt + 3) / 4;
      for (int b = 0; b < nb; b++) begin
        exp_d[exp_n] = mem_word(dptr[i] + 32'(4 * b));
        exp_n++;
      end
      exp_mark = exp_mark | dflg[i][30];
      exp_end  = exp_end | dflg[i][31];
      exp_idx  = i;
      if (dflg[i][29] || dflg[i][31]) break;
    end
  endtask

  task automatic run_list(input logic [31:0] ctl);
    wr(2'd2, 32'h3);
    got_n = 0;
    wr(2'd0, TBL);
    wr(2'd1, ctl | 32'h1);
    while (status_out[3]) @(negedge clk);
    build_expect();
  endtask

  task automatic cmp_stream(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < exp_n && i < got_n; i++) if (got[i] != exp_d[i]) bad++;
    chk(bad == 0 && got_n == exp_n, req, "beat stream count", 32'(got_n), 32'(exp_n));
  endtask

  task automatic clear_list();
    for (int i = 0; i < 16; i++) begin dptr[i] = 32'h0005_0000 + 32'(i * 32'h100); dflg[i] = 0; end
  endtask

  initial begin
    void'($urandom(32'd4242));
    clear_list();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R11 index reads 0xFF)
    chk(status_out == 8'h00, "R3", "reset status", 32'(status_out), 32'h0);
    chk(irq == 1'b0, "R9", "reset irq", 32'(irq), 32'h0);
    chk(pos_out == 32'hFF00_0000, "R11", "reset position", pos_out, 32'hFF00_0000);
    chk(mem_req == 1'b0, "R2", "reset request", 32'(mem_req), 32'h0);

    // three segments, mark on 0 and 2, end on 2, interrupts disabled
    clear_list();
    dptr[0] = 32'h0002_0000; dflg[0] = 32'h4000_0008;
    dptr[1] = 32'h0002_0100; dflg[1] = 32'h0000_0005;
    dptr[2] = 32'h0002_0200; dflg[2] = 32'hC000_000C;
    run_list(32'h0);
    cmp_stream("R2");
    chk(status_out[0] == 1'b1, "R3", "end-of-list bit", 32'(status_out), 32'h1);
    chk(status_out[1] == 1'b1, "R5", "mark bit", 32'(status_out), 32'h2);
    chk(status_out[3] == 1'b0 && mem_req == 1'b0, "R3", "idle after list", 32'(status_out), 32'h3);
    chk(irq == 1'b0, "R9", "irq masked", 32'(irq), 32'h0);
    chk(pos_out == 32'h0200_0000, "R11", "final position", pos_out, 32'h0200_0000);

    // write-one-to-clear
    wr(2'd2, 32'h2);
    chk(status_out[1:0] == 2'b01, "R8", "clear mark only", 32'(status_out[1:0]), 32'h1);
    wr(2'd2, 32'h0);
    chk(status_out[1:0] == 2'b01, "R8", "zero write keeps", 32'(status_out[1:0]), 32'h1);
    wr(2'd2, 32'h1);
    chk(status_out[1:0] == 2'b00, "R8", "clear end", 32'(status_out[1:0]), 32'h0);

    // interrupt enables
    clear_list();
    dptr[0] = 32'h0002_0400; dflg[0] = 32'hC000_0004;
    run_list(32'h8);
    chk(irq == 1'b1 && status_out[2] == 1'b1, "R9", "irq on end", 32'(status_out), 32'h7);
    wr(2'd2, 32'h1);
    chk(irq == 1'b0, "R9", "irq off after clear", 32'(irq), 32'h0);
    run_list(32'h10);
    chk(irq == 1'b1, "R9", "irq on mark", 32'(irq), 32'h1);
    wr(2'd2, 32'h2);
    chk(irq == 1'b0 && status_out[0] == 1'b1, "R9", "end not enabled", 32'(status_out), 32'h1);

    // zero-count segment
    clear_list();
    zero_hits = 0;
    dptr[0] = ZPTR;           dflg[0] = 32'h4000_0000;
    dptr[1] = 32'h0002_0600;  dflg[1] = 32'h8000_0004;
    run_list(32'h0);
    cmp_stream("R10");
    chk(zero_hits == 0, "R10", "empty buffer read", 32'(zero_hits), 32'h0);
    chk(status_out[1] == 1'b1, "R10", "empty segment mark", 32'(status_out), 32'h2);
    chk(pos_out == 32'h0100_0000, "R11", "position after empty", pos_out, 32'h0100_0000);

    // descriptor halt flag
    clear_list();
    dptr[0] = 32'h0002_0800; dflg[0] = 32'h0000_0006;
    dptr[1] = 32'h0002_0900; dflg[1] = 32'h2000_0009;
    dptr[2] = 32'h0002_0A00; dflg[2] = 32'h8000_0010;
    run_list(32'h4);
    cmp_stream("R6");
    chk(status_out[0] == 1'b0 && status_out[3] == 1'b0, "R6", "halted before end", 32'(status_out), 32'h0);
    chk(pos_out == 32'h0100_0000, "R6", "halt index", pos_out, 32'h0100_0000);

    // position mid-segment, then software halt
    clear_list();
    dptr[0] = 32'h0002_0C00; dflg[0] = 32'h8000_0028;
    wr(2'd2, 32'h3);
    wr(2'd0, TBL);
    wr(2'd1, 32'h1);
    chk(pos_out == 32'hFF00_0000, "R11", "index before completion", pos_out, 32'hFF00_0000);
    begin
      int n;
      n = 0;
      while (n < 3) begin @(negedge clk); if (out_valid) n++; end
    end
    @(negedge clk);
    chk(pos_out == 32'hFF00_001C, "R11", "bytes remaining", pos_out, 32'hFF00_001C);
    wr(2'd1, 32'h2);
    chk(status_out[3] == 1'b0 && mem_req == 1'b0, "R7", "software halt", 32'(status_out), 32'h0);
    wr(2'd1, 32'h0);

    // looping ring
    clear_list();
    dptr[0] = 32'h0002_0E00; dflg[0] = 32'h4000_0008;
    dptr[1] = 32'h0002_0F00; dflg[1] = 32'h8000_0004;
    wr(2'd2, 32'h3);
    got_n = 0;
    wr(2'd0, TBL);
    wr(2'd1, 32'h5);
    while (got_n < 8) @(negedge clk);
    wr(2'd1, 32'h2);
    wr(2'd1, 32'h0);
    build_expect();
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 7; i++) if (got[i] != exp_d[i % 3]) bad++;
      chk(bad == 0, "R4", "repeated passes", 32'(bad), 32'h0);
    end
    chk(status_out[0] == 1'b1 && status_out[3] == 1'b0, "R4", "loop end flag", 32'(status_out), 32'h1);

    // random lists
    for (int t = 0; t < 8; t++) begin
      int n;
      clear_list();
      n = 1 + int'($urandom % 5);
      for (int i = 0; i < n; i++) begin
        dptr[i] = 32'h0006_0000 + 32'(t * 32'h1000) + 32'(i * 32'h100);
        dflg[i] = 32'($urandom % 40);
        if ($urandom % 4 == 0) dflg[i] = 0;
        if ($urandom % 2 == 0) dflg[i][30] = 1'b1;
        if (i > 0 && i < n - 1 && $urandom % 6 == 0) dflg[i][29] = 1'b1;
      end
      dflg[n-1][31] = 1'b1;
      run_list(32'h0);
      cmp_stream("R2");
      chk(status_out[1:0] == {exp_mark, exp_end}, "R5", "random events",
          32'(status_out[1:0]), 32'({exp_mark, exp_end}));
      chk(pos_out == {8'(exp_idx), 24'd0}, "R11", "random position", pos_out, {8'(exp_idx), 24'd0});
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule